// File: doc/BRIEF.md
# Frequency-Count Successive-Approximation Calibration Controller

This block trims an 8-bit current DAC so that the frequency shift it adds to an oscillator matches a programmed target. It does this by counting cycles: a counter clocked by the oscillator counts whole oscillator periods while a timer clocked by the reference clock opens a window of a programmed number of reference cycles. The first window runs with modulation off and gives a baseline (center) count, which is stored once. Modulation is then switched on. For each DAC bit, from the most significant down, the controller opens a new window and measures a shifted count. The difference from the baseline is compared against an expected delta, and the sign of the result decides whether the bit under test is kept.

A calibration starts with a one-cycle request on the reference clock. Eight decisions later the done flag rises with the pass flag still high. If the oscillator counter saturates, or if a window result does not come back across the clock boundary in time, the run stops early with done high and pass low. The sequencing logic runs in the reference domain. The gate and the result cross to and from the oscillator domain through two-flop synchronizers and a toggle handshake. No data stream crosses the block's edge, so every pin is a plain control or status level and there is no valid/ready handshake or back-pressure.

Top module: `freq_cal_ctrl`

## Requirements
- R1: A `cal_start` pulse sampled while the controller is idle makes `cal_pass` = 1, `cal_done` = 0, `mod_en` = 0 and `dac_code` = 0 at the next `ref_clk` edge.
- R2: After `settle_len` reference cycles (0 counts as 1), the controller opens a window of `base_len` reference cycles (0 counts as 1). The oscillator cycles counted in that window, within ±2 for synchronizer skew, are stored in `center_count`.
- R3: Once the center count is stored, `mod_en` goes to 1 and stays 1 for every later measurement. Each later measurement waits `settle_len` cycles and then counts over a window of `shift_len` reference cycles.
- R4: For each trial, delta = shifted count − `center_count` and error = `expect_delta` (two's complement) − delta. The bit under test is cleared when the error is negative and kept when it is zero or positive. For a delta that rises with the code, the final code is the largest code whose delta does not exceed `expect_delta`, or 0 when there is no such code.
- R5: The search goes from bit 7 down to bit 0, and each trial first sets its bit to 1. The first trial code is therefore 8'h80.
- R6: `center_count` does not change while the delta measurements repeat.
- R7: After exactly eight decisions, `cal_done` = 1 and `cal_pass` stays 1. `mod_en` stays 1 and `dac_code` holds the final code.
- R8: If the oscillator counter reaches its maximum of 2^CNT_W − 1 in a window, the run aborts with `cal_done` = 1, `cal_pass` = 0 and `mod_en` = 0.
- R9: If a window result has not returned within TMO_CYC reference cycles after the gate closes, the run aborts with `cal_done` = 1, `cal_pass` = 0 and `mod_en` = 0.
- R10: A `cal_start` pulse that arrives while a calibration is running is ignored. `cal_done` stays 0 and the run finishes as if the pulse had not occurred.
- R11: After reset, `cal_pass`, `cal_done` and `mod_en` are 0, and `dac_code` and `center_count` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; sequencing and window timer |
| osc_clk | input | 1 | Oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cal_start | input | 1 | One-cycle calibration request (ref domain) |
| base_len | input | LEN_W | Window length in reference cycles for the center count |
| shift_len | input | LEN_W | Window length in reference cycles for each delta count |
| expect_delta | input | CNT_W+1 | Target delta, two's complement |
| settle_len | input | SET_W | Settle wait in reference cycles before each window |
| mod_en | output | 1 | Enables modulation on the oscillator |
| dac_code | output | DAC_W | Calibration DAC code |
| center_count | output | CNT_W | Stored baseline oscillator count |
| cal_pass | output | 1 | Pass status |
| cal_done | output | 1 | Done status |

## Verification
The assertions check, on every reference cycle, the rules that hold at any moment. An idle start arms the status flags. The center count stays frozen while the delta passes run. Done is never high while the controller is busy. Pass only falls together with done. The DAC code never moves while the controller sits idle. The bench scenarios are needed to show what depends on the oscillator model: that the stored center matches the cycles actually counted, that the search lands on the right code for different window lengths and targets including a negative one, that the first trial is 8'h80, and that saturation, a dead oscillator and a start during a run are each handled as required.

// File: rtl/fcal_pkg.sv
`timescale 1ns/1ps
package fcal_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SETTLE = 2'd1,
    S_COUNT  = 2'd2,
    S_WAIT   = 2'd3
  } fcal_state_t;
endpackage

// File: rtl/fcal_sync2.sv
`timescale 1ns/1ps
module fcal_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/fcal_osc_counter.sv
`timescale 1ns/1ps
module fcal_osc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             gate_req,
  output logic [CNT_W-1:0] hold_cnt,
  output logic             hold_sat,
  output logic             done_tgl
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             gate_s, gate_d;
  logic [CNT_W-1:0] cnt_q;
  logic             sat_q;

  fcal_sync2 #(.W(1)) u_gate_sync (
    .clk(osc_clk), .rst_n(rst_n), .d(gate_req), .q(gate_s)
  );

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d   <= 1'b0;
      cnt_q    <= '0;
      sat_q    <= 1'b0;
      hold_cnt <= '0;
      hold_sat <= 1'b0;
      done_tgl <= 1'b0;
    end else begin
      gate_d <= gate_s;
      if (gate_s && !gate_d) begin
        cnt_q <= '0;
        sat_q <= 1'b0;
      end else if (gate_s) begin
        if (cnt_q == CNT_MAX) sat_q <= 1'b1;
        else                  cnt_q <= cnt_q + 1'b1;
      end
      if (!gate_s && gate_d) begin
        hold_cnt <= cnt_q;
        hold_sat <= sat_q || (cnt_q == CNT_MAX);
        done_tgl <= ~done_tgl;
      end
    end
  end
endmodule

// File: rtl/fcal_ref_timer.sv
`timescale 1ns/1ps
module fcal_ref_timer #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fcal_sar.sv
`timescale 1ns/1ps
module fcal_sar #(
  parameter int DAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             init,
  input  logic             step,
  input  logic             keep,
  output logic [DAC_W-1:0] code,
  output logic             last
);
  localparam int IDX_W = (DAC_W > 1) ? $clog2(DAC_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DAC_W - 1);

  logic [IDX_W-1:0] idx_q;
  logic [DAC_W-1:0] code_nx;

  always_comb begin
    code_nx = code;
    if (!keep) code_nx[idx_q] = 1'b0;
    if (idx_q != '0) code_nx[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      idx_q <= TOP_IDX;
    end else if (clr) begin
      code  <= '0;
      idx_q <= TOP_IDX;
    end else if (init) begin
      code          <= '0;
      code[TOP_IDX] <= 1'b1;
      idx_q         <= TOP_IDX;
    end else if (step) begin
      code <= code_nx;
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign last = (idx_q == '0);
endmodule

// File: rtl/freq_cal_ctrl.sv
`timescale 1ns/1ps
module freq_cal_ctrl
  import fcal_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int LEN_W   = 12,
  parameter int SET_W   = 8,
  parameter int DAC_W   = 8,
  parameter int TMO_CYC = 64
) (
  input  logic               ref_clk,
  input  logic               osc_clk,
  input  logic               rst_n,
  input  logic               cal_start,
  input  logic [LEN_W-1:0]   base_len,
  input  logic [LEN_W-1:0]   shift_len,
  input  logic [CNT_W:0]     expect_delta,
  input  logic [SET_W-1:0]   settle_len,
  output logic               mod_en,
  output logic [DAC_W-1:0]   dac_code,
  output logic [CNT_W-1:0]   center_count,
  output logic               cal_pass,
  output logic               cal_done
);
  localparam int BIG_W = (LEN_W > SET_W) ? LEN_W : SET_W;
  localparam int TMR_W = BIG_W + 1;
  localparam logic [TMR_W-1:0] TMO_LAST = TMR_W'(TMO_CYC - 1);

  fcal_state_t state_q, state_d;
  logic meas_delta_q, gate_q, busy;
  logic [TMR_W-1:0] tmr, tmr_nx, win_len;
  logic tmr_clr;

  logic [CNT_W-1:0] hold_cnt;
  logic hold_sat, done_tgl, tgl_s, tgl_d, res_vld;

  logic signed [CNT_W+1:0] delta_s, err_s;
  logic keep, sar_last, sar_clr, sar_init, sar_step;
  logic accept, res_ok, abort_tmo;

  assign busy    = (state_q != S_IDLE);
  assign tmr_nx  = tmr + 1'b1;
  assign win_len = meas_delta_q ? TMR_W'(shift_len) : TMR_W'(base_len);

  fcal_ref_timer #(.W(TMR_W)) u_tmr (
    .clk(ref_clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr)
  );

  fcal_osc_counter #(.CNT_W(CNT_W)) u_osc (
    .osc_clk(osc_clk), .rst_n(rst_n), .gate_req(gate_q),
    .hold_cnt(hold_cnt), .hold_sat(hold_sat), .done_tgl(done_tgl)
  );

  fcal_sync2 #(.W(1)) u_tgl_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(done_tgl), .q(tgl_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tgl_d <= 1'b0;
    else        tgl_d <= tgl_s;
  end
  assign res_vld = tgl_s ^ tgl_d;

  // trial comparison: error = expect - (shifted - center)
  assign delta_s = $signed({2'b00, hold_cnt}) - $signed({2'b00, center_count});
  assign err_s   = $signed({expect_delta[CNT_W], expect_delta}) - delta_s;
  assign keep    = !err_s[CNT_W+1];

  assign accept    = (state_q == S_IDLE) && cal_start;
  assign res_ok    = (state_q == S_WAIT) && res_vld && !hold_sat;
  assign abort_tmo = (state_q == S_WAIT) && !res_vld && (tmr >= TMO_LAST);
  assign sar_clr   = accept;
  assign sar_init  = res_ok && !meas_delta_q;
  assign sar_step  = res_ok && meas_delta_q;

  fcal_sar #(.DAC_W(DAC_W)) u_sar (
    .clk(ref_clk), .rst_n(rst_n), .clr(sar_clr), .init(sar_init),
    .step(sar_step), .keep(keep), .code(dac_code), .last(sar_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (cal_start) state_d = S_SETTLE;
      S_SETTLE: if (tmr_nx >= TMR_W'(settle_len)) state_d = S_COUNT;
      S_COUNT:  if (tmr_nx >= win_len) state_d = S_WAIT;
      S_WAIT: begin
        if (res_vld) begin
          if (hold_sat)                     state_d = S_IDLE;
          else if (meas_delta_q && sar_last) state_d = S_IDLE;
          else                              state_d = S_SETTLE;
        end else if (abort_tmo) begin
          state_d = S_IDLE;
        end
      end
      default:  state_d = S_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      meas_delta_q <= 1'b0;
      gate_q       <= 1'b0;
      mod_en       <= 1'b0;
      center_count <= '0;
      cal_pass     <= 1'b0;
      cal_done     <= 1'b0;
    end else begin
      state_q <= state_d;
      gate_q  <= (state_d == S_COUNT);
      if (accept) begin
        cal_pass     <= 1'b1;
        cal_done     <= 1'b0;
        mod_en       <= 1'b0;
        meas_delta_q <= 1'b0;
      end
      if ((state_q == S_WAIT) && res_vld && hold_sat) begin
        cal_pass <= 1'b0;
        cal_done <= 1'b1;
        mod_en   <= 1'b0;
      end
      if (abort_tmo) begin
        cal_pass <= 1'b0;
        cal_done <= 1'b1;
        mod_en   <= 1'b0;
      end
      if (sar_init) begin
        center_count <= hold_cnt;
        mod_en       <= 1'b1;
        meas_delta_q <= 1'b1;
      end
      if (sar_step && sar_last) cal_done <= 1'b1;
    end
  end
endmodule

// File: rtl/fcal_chk.sv
`timescale 1ns/1ps
module fcal_chk #(
  parameter int CNT_W = 12,
  parameter int DAC_W = 8
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             cal_start,
  input logic             busy,
  input logic             mod_en,
  input logic             cal_pass,
  input logic             cal_done,
  input logic [CNT_W-1:0] center_count,
  input logic [DAC_W-1:0] dac_code
);
  a_r1_start_arms: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!busy && cal_start) |=> (cal_pass && !cal_done && !mod_en));

  a_r6_center_held: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (busy && mod_en) |=> $stable(center_count));

  a_r7_done_idle: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cal_done |-> !busy);

  a_r8_pass_drop_done: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(cal_pass) |-> cal_done);

  a_r10_code_frozen_idle: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!busy && !cal_start) |=> $stable(dac_code));
endmodule

bind freq_cal_ctrl fcal_chk #(.CNT_W(CNT_W), .DAC_W(DAC_W)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .cal_start(cal_start), .busy(busy),
  .mod_en(mod_en), .cal_pass(cal_pass), .cal_done(cal_done),
  .center_count(center_count), .dac_code(dac_code)
);

// File: tb/sim_freq_cal_ctrl.sv
`timescale 1ns/1ps
module sim_freq_cal_ctrl;
  localparam int CNT_W = 12;
  localparam int LEN_W = 12;
  localparam int SET_W = 8;
  localparam int DAC_W = 8;
  localparam int NVEC  = 6;
  // base_len, shift_len, expect_delta, settle_len
  localparam int VEC [NVEC][4] = '{
    '{64, 64, 200, 8},
    '{64, 64, 0, 4},
    '{64, 64, 600, 8},
    '{64, 128, 700, 6},
    '{96, 64, 100, 8},
    '{96, 64, -200, 3}
  };

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 1'b0;
  logic osc_stop = 1'b0;
  logic [LEN_W-1:0] base_len = '0, shift_len = '0;
  logic [CNT_W:0]   expect_delta = '0;
  logic [SET_W-1:0] settle_len = '0;
  logic mod_en, cal_pass, cal_done;
  logic [DAC_W-1:0] dac_code;
  logic [CNT_W-1:0] center_count;

  int total = 0;
  int bad = 0;
  real half_ns;

  freq_cal_ctrl u0 (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n), .cal_start(cal_start),
    .base_len(base_len), .shift_len(shift_len), .expect_delta(expect_delta),
    .settle_len(settle_len), .mod_en(mod_en), .dac_code(dac_code),
    .center_count(center_count), .cal_pass(cal_pass), .cal_done(cal_done)
  );

  always #4 ref_clk = ~ref_clk;

  // oscillator model: 0.5 GHz plus 4 MHz per code step while modulating
  always begin
    half_ns = 0.5 / (0.5 + (mod_en ? 0.004 * real'(dac_code) : 0.0));
    #(half_ns);
    if (!osc_stop) osc_clk = ~osc_clk;
  end

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_code(int lb, int ls, int ex);
    for (int c = 255; c >= 0; c--) begin
      if (4000 * ls + 32 * c * ls - 4000 * lb <= ex * 1000) return c;
    end
    return 0;
  endfunction

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic pulse_start();
    @(negedge ref_clk) cal_start = 1'b1;
    @(negedge ref_clk) cal_start = 1'b0;
  endtask

  task automatic wait_done(input int lim, output bit hit);
    hit = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge ref_clk);
      if (cal_done) begin hit = 1'b1; break; end
    end
  endtask

  task automatic load(input int v[4]);
    base_len     = LEN_W'(v[0]);
    shift_len    = LEN_W'(v[1]);
    expect_delta = (CNT_W+1)'(v[2]);
    settle_len   = SET_W'(v[3]);
  endtask

  initial begin
    bit hit;
    int want;
    int ctr_mid;
    repeat (3) @(negedge ref_clk);
    // R11 reset state
    chk(!cal_pass && !cal_done && !mod_en, "R11 flags", {cal_pass, cal_done, mod_en}, 0);
    chk(dac_code == 0 && center_count == 0, "R11 regs", dac_code + center_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge ref_clk);

    for (int k = 0; k < NVEC; k++) begin
      load(VEC[k]);
      pulse_start();
      chk(cal_pass && !cal_done && !mod_en, "R1 armed", {cal_pass, cal_done, mod_en}, 3'b100);
      wait_done(5000, hit);
      chk(hit, "R7 done reached", hit, 1);
      chk(cal_pass && mod_en, "R7 pass and mod_en kept", {cal_pass, mod_en}, 2'b11);
      chk(absd(center_count, 4 * VEC[k][0]) <= 2, "R2 center", center_count, 4 * VEC[k][0]);
      want = model_code(VEC[k][0], VEC[k][1], VEC[k][2]);
      chk(absd(dac_code, want) <= 3, "R4 code", dac_code, want);
      repeat (3) @(negedge ref_clk);
    end

    // directed: first trial, mod enable, held center, start while busy
    load(VEC[0]);
    pulse_start();
    hit = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge ref_clk);
      if (mod_en) begin hit = 1'b1; break; end
    end
    chk(hit, "R3 mod_en rises", hit, 1);
    chk(dac_code == 8'h80, "R5 first trial", dac_code, 8'h80);
    ctr_mid = center_count;
    repeat (100) @(negedge ref_clk);
    chk(mod_en, "R3 mod_en held", mod_en, 1);
    pulse_start();
    chk(!cal_done && cal_pass, "R10 start ignored", {cal_done, cal_pass}, 2'b01);
    wait_done(5000, hit);
    chk(hit && cal_pass, "R10 run completes", {hit, cal_pass}, 2'b11);
    chk(center_count == ctr_mid, "R6 center held", center_count, ctr_mid);
    want = model_code(VEC[0][0], VEC[0][1], VEC[0][2]);
    chk(absd(dac_code, want) <= 3, "R10 code unaffected", dac_code, want);

    // saturation: 1100 windows at 0.5 GHz exceed 4095
    base_len = 12'd1100; settle_len = 8'd4;
    pulse_start();
    wait_done(5000, hit);
    chk(hit && !cal_pass && !mod_en, "R8 saturation abort", {hit, cal_pass, mod_en}, 3'b100);

    // timeout: oscillator stopped
    base_len = 12'd64;
    osc_stop = 1'b1;
    pulse_start();
    chk(cal_pass && !cal_done, "R1 pass re-armed", {cal_pass, cal_done}, 2'b10);
    wait_done(1000, hit);
    chk(hit && !cal_pass && !mod_en, "R9 timeout abort", {hit, cal_pass, mod_en}, 3'b100);
    osc_stop = 1'b0;
    @(negedge ref_clk) rst_n = 1'b0;
    @(negedge ref_clk);
    chk(!cal_pass && !cal_done && dac_code == 0, "R11 reset again", {cal_pass, cal_done}, 0);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule